// File: doc/BRIEF.md
# Transfer Activation Sequencer with Descriptor Reuse

This block answers each activation request of a data transfer controller. Every request carries a vector number. The block then decides whether to read the vector word and the two-word transfer descriptor from memory, or to start at once with the descriptor it already holds. Reuse is allowed only when all of these are true: the vector number equals the previous one, reuse is enabled, the held copy is valid, and the previous activation did not chain. After that the block starts one transfer step on the datapath and updates the held 8-bit counter pair. It then either finishes or moves on to the next descriptor in memory.

Memory is read through a request/acknowledge port. An error response on that port aborts the activation. The datapath is driven by a one-cycle start pulse and answers with a done pulse. An 8-bit control register holds two enables and a sticky error flag. The vector table sits at `VEC_BASE`, one word per vector, and each entry holds the address of a descriptor. A descriptor is two words: a control word, then a count word.

Top module: `dtc_fetch_seq`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `busy` is 0, and no memory request or transfer start is issued while idle.
- R2: Control register bit 4 is the reuse enable and bit 3 is the chain-after-reload enable, both read/write. Bits 7:5 and 2:1 always read 0 and ignore writes.
- R3: Register bit 0 is the error flag. A bus error sets it. Only a write with bit 0 equal to 0 clears it. Writing 1 leaves it unchanged.
- R4: The first activation after reset always fetches. Every fetch follows this order: vector word at `VEC_BASE`+vector, then control word at descriptor address D, then count word at D+1, then the transfer start. Each read waits for its acknowledge.
- R5: If the vector equals the previous vector, reuse is enabled, the held descriptor is valid and the previous activation did not chain, no memory read is made. The transfer starts from the held descriptor and counter.
- R6: A vector mismatch, or reuse disabled, causes the full fetch of R4.
- R7: After an activation that chained, the next activation always does the full fetch, even if the vector matches and reuse is enabled.
- R8: Normal mode (control word bit 14 = 0): each finished transfer decrements the low counter (count word bits 7:0). If it reaches 0 and the chain bit (control word bit 15) is 1, the block reads the next descriptor at D+2 and D+3 and runs it. Otherwise the activation ends.
- R9: Repeat mode (control word bit 14 = 1): when the decremented low counter reaches 0, it is reloaded from the high counter (count word bits 15:8). A chain follows that reload only if the chain bit and the chain-after-reload enable are both 1.
- R10: A bus error on any read aborts the activation with an `act_done` pulse, sets the error flag and marks the held descriptor invalid, so the next activation fetches.
- R11: `mem_req` and `mem_addr` stay steady until an acknowledge or error arrives. `xfer_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | 1 | Activation request pulse, accepted while idle |
| act_vec | input | VEC_W | Vector number of the request |
| busy | output | 1 | An activation is in progress |
| act_done | output | 1 | One-cycle pulse when the activation ends or aborts |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_err | input | 1 | Read error response |
| mem_rdata | input | 16 | Read data |
| xfer_start | output | 1 | Start pulse for one transfer step |
| xfer_done | input | 1 | Transfer step finished |
| cnt_lo | output | 8 | Held low counter |

## Verification
The same vector is repeated with reuse off and then with reuse on. This separates a refetched descriptor, which restores the counter, from a reused one, which keeps counting down. A vector change, a repeat after a chain and a repeat after a bus error are each run with reuse enabled. These show that each of the three conditions alone forces the full fetch order. Repeat descriptors are run with the chain-after-reload enable cleared and then set. This separates a reload that ends the activation from one that reads the next descriptor. A normal-mode descriptor whose counter reaches zero with its chain bit set shows the D+2 walk.

// File: rtl/dtc_fetch_seq.sv
module dtc_fetch_seq #(
  parameter int VEC_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic [VEC_W-1:0]  act_vec,
  output logic              busy,
  output logic              act_done,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [15:0]       mem_rdata,
  output logic              xfer_start,
  input  logic              xfer_done,
  output logic [7:0]        cnt_lo
);
  typedef enum logic [2:0] {S_IDLE, S_VEC, S_D0, S_D1, S_START, S_WAIT, S_DONE} st_t;
  st_t st;

  logic              skip_en, rchain_en, err_flag;
  logic              held_ok, chained;
  logic [VEC_W-1:0]  last_vec;
  logic [ADDR_W-1:0] dptr;
  logic              d_chain, d_rpt;
  logic [7:0]        lo, hi;

  wire fetching = (st == S_VEC) || (st == S_D0) || (st == S_D1);
  wire bus_fail = fetching && mem_err;
  wire bus_ok   = fetching && mem_ack && !mem_err;
  wire reuse    = held_ok && (act_vec == last_vec) && skip_en && !chained;

  wire [7:0] dec    = lo - 8'd1;
  wire       reload = d_rpt && (dec == 8'd0);
  wire       go_chn = d_chain && (d_rpt ? (reload && rchain_en) : (dec == 8'd0));

  assign busy       = (st != S_IDLE);
  assign act_done   = (st == S_DONE);
  assign xfer_start = (st == S_START);
  assign mem_req    = fetching;
  assign cnt_lo     = lo;
  assign reg_rdata  = {3'b000, skip_en, rchain_en, 2'b00, err_flag};

  always_comb begin
    case (st)
      S_VEC:   mem_addr = VEC_BASE + ADDR_W'(last_vec);
      S_D0:    mem_addr = dptr;
      S_D1:    mem_addr = dptr + ADDR_W'(1);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_en   <= 1'b0;
      rchain_en <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (reg_we) begin
        skip_en   <= reg_wdata[4];
        rchain_en <= reg_wdata[3];
      end
      if (bus_fail)
        err_flag <= 1'b1;
      else if (reg_we && !reg_wdata[0])
        err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      held_ok  <= 1'b0;
      chained  <= 1'b0;
      last_vec <= '0;
      dptr     <= '0;
      d_chain  <= 1'b0;
      d_rpt    <= 1'b0;
      lo       <= '0;
      hi       <= '0;
    end else if (bus_fail) begin
      held_ok <= 1'b0;
      st      <= S_DONE;
    end else begin
      case (st)
        S_IDLE:
          if (act_req) begin
            last_vec <= act_vec;
            chained  <= 1'b0;
            st       <= reuse ? S_START : S_VEC;
          end
        S_VEC:
          if (bus_ok) begin
            dptr <= ADDR_W'(mem_rdata);
            st   <= S_D0;
          end
        S_D0:
          if (bus_ok) begin
            d_chain <= mem_rdata[15];
            d_rpt   <= mem_rdata[14];
            st      <= S_D1;
          end
        S_D1:
          if (bus_ok) begin
            hi      <= mem_rdata[15:8];
            lo      <= mem_rdata[7:0];
            held_ok <= 1'b1;
            st      <= S_START;
          end
        S_START: st <= S_WAIT;
        S_WAIT:
          if (xfer_done) begin
            lo <= reload ? hi : dec;
            if (go_chn) begin
              chained <= 1'b1;
              dptr    <= dptr + ADDR_W'(2);
              st      <= S_D0;
            end else begin
              st <= S_DONE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dtc_fetch_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              reg_we,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              xfer_start
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !xfer_start));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:5] == 3'b000) && (reg_rdata[2:1] == 2'b00));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !(reg_we && !reg_wdata[0])) |=> reg_rdata[0]);

  p_err_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> reg_rdata[0]);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
endmodule

bind dtc_fetch_seq dtc_fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .mem_err(mem_err), .xfer_start(xfer_start)
);

// File: tb/test_dtc_fetch_seq.sv
module test_dtc_fetch_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        act_req = 0;
  logic [7:0]  act_vec = '0;
  logic        busy, act_done;
  logic        reg_we = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 0, mem_err = 0;
  logic [15:0] mem_rdata = '0;
  logic        xfer_start;
  logic        xfer_done = 0;
  logic [7:0]  cnt_lo;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] mem [256];
  logic [15:0] err_addr = 16'hFFFF;
  int exp_q[$];
  logic pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtc_fetch_seq i_dtc_fetch_seq (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_vec(act_vec), .busy(busy),
    .act_done(act_done), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .xfer_start(xfer_start), .xfer_done(xfer_done), .cnt_lo(cnt_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: memory responder and fetch-order scoreboard
  always @(negedge clk) begin
    if (mem_req && !mem_ack && !mem_err) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected fetch", int'(mem_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(mem_addr) == e, "R4 fetch address", int'(mem_addr), e);
      end
      if (mem_addr == err_addr) mem_err = 1;
      else begin
        mem_ack = 1;
        mem_rdata = mem[mem_addr[7:0]];
      end
    end else begin
      mem_ack = 0;
      mem_err = 0;
    end
    xfer_done = pend;
    pend = xfer_start;
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic activate(input logic [7:0] v);
    @(negedge clk); act_req = 1; act_vec = v;
    @(negedge clk); act_req = 0;
    while (!act_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] v, input int fetches[$], input int exp_cnt, input string req);
    foreach (fetches[i]) exp_q.push_back(fetches[i]);
    activate(v);
    check(exp_q.size() == 0, {req, " missing fetches"}, exp_q.size(), 0);
    exp_q.delete();
    if (exp_cnt >= 0) check(int'(cnt_lo) == exp_cnt, {req, " counter"}, cnt_lo, exp_cnt);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h03] = 16'h0040; mem[8'h40] = 16'h0000; mem[8'h41] = 16'h0005;
    mem[8'h05] = 16'h0050; mem[8'h50] = 16'h4000; mem[8'h51] = 16'h0301;
    mem[8'h07] = 16'h0060; mem[8'h60] = 16'h8000; mem[8'h61] = 16'h0001;
    mem[8'h62] = 16'h0000; mem[8'h63] = 16'h0009;
    mem[8'h09] = 16'h0070; mem[8'h70] = 16'hC000; mem[8'h71] = 16'h0201;
    mem[8'h72] = 16'h0000; mem[8'h73] = 16'h0004;
    mem[8'h0B] = 16'h0090;
    mem[8'h0D] = 16'h0080; mem[8'h80] = 16'h0000; mem[8'h81] = 16'h0006;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1 reset register", reg_rdata, 8'h00);
    check(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    wr(8'hFF);
    check(reg_rdata == 8'h18, "R2 reserved bits and R3 write-1 ignored", reg_rdata, 8'h18);
    wr(8'h00);
    check(reg_rdata == 8'h00, "R2 enables cleared", reg_rdata, 8'h00);

    run(8'h03, '{3, 'h40, 'h41}, 4, "R4 first activation");
    run(8'h03, '{3, 'h40, 'h41}, 4, "R6 reuse disabled");
    wr(8'h10);
    run(8'h03, '{}, 3, "R5 reuse of held descriptor");
    run(8'h05, '{5, 'h50, 'h51}, 3, "R6 R9 vector change, repeat reload");
    run(8'h05, '{}, 2, "R9 repeat no reload");
    run(8'h07, '{7, 'h60, 'h61, 'h62, 'h63}, 8, "R8 normal chain at zero");
    run(8'h07, '{7, 'h60, 'h61, 'h62, 'h63}, 8, "R7 fetch after chain");
    run(8'h09, '{9, 'h70, 'h71}, 2, "R9 reload without chain enable");
    wr(8'h18);
    run(8'h09, '{}, 1, "R9 reuse before reload");
    run(8'h09, '{'h72, 'h73}, 3, "R9 reload with chain enable");

    err_addr = 16'h000B;
    run(8'h0B, '{'h0B}, -1, "R10 error on vector read");
    check(reg_rdata == 8'h19, "R3 R10 error flag set", reg_rdata, 8'h19);
    wr(8'h19);
    check(reg_rdata == 8'h19, "R3 write 1 keeps flag", reg_rdata, 8'h19);
    err_addr = 16'h0081;
    run(8'h0D, '{'h0D, 'h80, 'h81}, -1, "R10 error on descriptor read");
    err_addr = 16'hFFFF;
    run(8'h0D, '{'h0D, 'h80, 'h81}, 5, "R10 invalidated descriptor refetched");
    wr(8'h18);
    check(reg_rdata == 8'h18, "R3 write 0 clears flag", reg_rdata, 8'h18);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule